// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block serialises one character at a time onto a single line that idles high. A character enters through a one-deep holding register using a valid/ready handshake. The shift engine takes it from there and sends a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a stop period at the mark level. Timing is set by an enable pulse that arrives at sixteen times the bit rate. A 1x mode instead treats each pulse as a whole bit time. Because the stop length is counted in sixteenths of a bit, fractional stop periods are possible.

Character length, parity, stop code and clock mode are captured when a character leaves the holding register. Changes to these inputs therefore only affect later characters. When clear-to-send checking is on, the engine looks at the active-low `cts_n` input only at a character boundary. While `cts_n` is high, the line stays at mark and the character waits in the holding register. Once a character has started, `cts_n` has no further influence on it.

Back-pressure rule: `in_ready` is high exactly when the holding register is empty. A character is accepted on a rising clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must keep `in_valid` and `in_data` unchanged.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1 and `tx_empty` is 1.
- R2: `in_ready` signals an empty holding register. While one character is shifting and a second is held, `in_ready` stays 0 and no further character is accepted.
- R3: A frame is one start bit at 0, then data bits least significant first. The data bit count is 5 + `char_len` (`char_len` 0..3 gives 5..8 bits). In 16x mode each start, data and parity bit lasts 16 `tick` pulses.
- R4: When `par_en` is 1, a parity bit follows the last data bit. It is the XOR of the data bits XOR `par_odd`, so `par_odd`=0 gives even and 1 gives odd overall parity.
- R5: In 16x mode the stop period at level 1 lasts 9, 16, 24 or 32 ticks for `stop_code` 0, 1, 2 and 3. For 5-bit characters, code 0 gives 16 ticks.
- R6: When `mode_1x` is 1, every start, data and parity bit lasts one tick. The stop period is 1 tick when `stop_code[1]` is 0 and 2 ticks when it is 1.
- R7: When a character is held at the last tick of a stop period and sending is allowed, its start bit begins at once, with no extra idle tick.
- R8: When `cts_en` is 1 and `cts_n` is 1 at a character boundary, `txd` stays 1 and the character stays held. When `cts_en` is 0, `cts_n` is ignored.
- R9: A change of `cts_n` after a start bit has begun does not alter that character's frame.
- R10: `tx_empty` is 1 only when the engine is idle and the holding register is empty. It rises on the tick after the last stop tick.
- R11: With nothing to send, `txd` is 1 and no start bit is generated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate enable pulse (16x, or 1x in 1x mode) |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character bits |
| in_ready | output | 1 | Holding register empty; character accepted when valid and ready |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| stop_code | input | 2 | Stop length code |
| mode_1x | input | 1 | 1 when each tick is one bit time |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | Engine idle and holding register empty |

## Verification
The assertions assume three things about the inputs. The source keeps `in_valid` and `in_data` steady while `in_ready` is low. `tick` and `cts_n` are already synchronous to `clk`. The configuration pins matter only at the tick that starts a character. The stimulus meets these conditions as follows: characters go in through a task that holds both signals until acceptance, `tick` is a single-cycle pulse on every other cycle, and the configuration changes only while `tx_empty` is high.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // stop period in ticks; sixteenths of a bit scaled by ovs
  function automatic int unsigned stop_ticks(input logic [1:0] code,
                                             input logic five_bit,
                                             input logic one_x,
                                             input int unsigned ovs);
    if (one_x) return code[1] ? 2 : 1;
    case (code)
      2'd0:    return five_bit ? ovs : (ovs * 9) / 16;
      2'd1:    return ovs;
      2'd2:    return (ovs * 3) / 2;
      default: return 2 * ovs;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_cts_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] held_data
);
  logic accept;
  assign in_ready = !full;
  assign accept   = in_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      held_data <= '0;
    end else if (accept) begin
      full      <= 1'b1;
      held_data <= in_data;
    end else if (take) begin
      full      <= 1'b0;
    end
  end

  AST_HOLD_KEEPS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(held_data))); // R2
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_cts_tx_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              odd,
  output logic              par
);
  logic [DATA_W-1:0] masked;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data[i] & (IDX_W'(i) <= last_idx);
  end

  assign par = (^masked) ^ odd;
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_cts_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop_code,
  input  logic              mode_1x,
  input  logic              cts_en,
  input  logic              cts_n,
  output logic              take,
  output logic              txd,
  output logic              idle
);
  localparam int unsigned CW = $clog2(2 * OVS + 1);

  tx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_q;
  logic [DATA_W-1:0] dat_q;
  logic              pen_q, par_q, one_x_q;
  logic [CW-1:0]     stop_len_q;

  logic [IDX_W-1:0]  last_d;
  logic [CW-1:0]     stop_len_d;
  logic              par_d;
  logic [CW-1:0]     bit_last;
  logic              bit_end, stop_end, cts_ok, boundary;

  assign last_d     = IDX_W'(4) + IDX_W'(char_len);
  assign stop_len_d = CW'(stop_ticks(stop_code, char_len == 2'd0, mode_1x, OVS));

  uart_tx_parity u_par (
    .data     (hold_data),
    .last_idx (last_d),
    .odd      (par_odd),
    .par      (par_d)
  );

  assign bit_last = one_x_q ? '0 : CW'(OVS - 1);
  assign bit_end  = (cnt == bit_last);
  assign stop_end = (cnt == stop_len_q - CW'(1));
  assign cts_ok   = !cts_en || !cts_n;
  assign boundary = (st == ST_IDLE) || ((st == ST_STOP) && stop_end);
  assign take     = tick && hold_full && cts_ok && boundary;
  assign idle     = (st == ST_IDLE);

  always_comb begin
    unique case (st)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = dat_q[idx];
      ST_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      idx        <= '0;
      last_q     <= '0;
      dat_q      <= '0;
      pen_q      <= 1'b0;
      par_q      <= 1'b0;
      one_x_q    <= 1'b0;
      stop_len_q <= CW'(1);
    end else if (tick) begin
      if (take) begin
        st         <= ST_START;
        cnt        <= '0;
        dat_q      <= hold_data;
        last_q     <= last_d;
        pen_q      <= par_en;
        par_q      <= par_d;
        one_x_q    <= mode_1x;
        stop_len_q <= stop_len_d;
      end else begin
        unique case (st)
          ST_IDLE: cnt <= '0;
          ST_START: begin
            if (bit_end) begin
              cnt <= '0;
              idx <= '0;
              st  <= ST_DATA;
            end else cnt <= cnt + CW'(1);
          end
          ST_DATA: begin
            if (bit_end) begin
              cnt <= '0;
              if (idx == last_q) st <= pen_q ? ST_PAR : ST_STOP;
              else idx <= idx + IDX_W'(1);
            end else cnt <= cnt + CW'(1);
          end
          ST_PAR: begin
            if (bit_end) begin
              cnt <= '0;
              st  <= ST_STOP;
            end else cnt <= cnt + CW'(1);
          end
          ST_STOP: begin
            if (stop_end) begin
              cnt <= '0;
              st  <= ST_IDLE;
            end else cnt <= cnt + CW'(1);
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_CTS_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cts_en && cts_n) |=> (st == ST_IDLE)); // R8
  AST_NO_START_WITHOUT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !hold_full) |=> (st == ST_IDLE)); // R11
  AST_STOP_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP) |-> (cnt < stop_len_q)); // R5
  AST_CHAR_NOT_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && st != ST_STOP) |=> (st != ST_IDLE)); // R9
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop_code,
  input  logic              mode_1x,
  input  logic              cts_en,
  input  logic              cts_n,
  output logic              txd,
  output logic              tx_empty
);
  logic              take, full, eng_idle;
  logic [DATA_W-1:0] held;

  uart_tx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .take      (take),
    .full      (full),
    .held_data (held)
  );

  uart_tx_engine #(.OVS(OVS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold_full (full),
    .hold_data (held),
    .char_len  (char_len),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .stop_code (stop_code),
    .mode_1x   (mode_1x),
    .cts_en    (cts_en),
    .cts_n     (cts_n),
    .take      (take),
    .txd       (txd),
    .idle      (eng_idle)
  );

  assign tx_empty = eng_idle && !full;

  AST_EMPTY_MEANS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && in_ready)); // R10
endmodule

// File: tb/tb_uart_cts_tx.sv
`timescale 1ns/1ps
module tb_uart_cts_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [1:0] stop_code = 2'd1;
  logic       mode_1x = 1'b0;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b1;
  logic       txd, tx_empty;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit smp_txd [0:2047];
  bit smp_emp [0:2047];
  int n_smp = 0;
  bit exp_txd [0:1023];
  int exp_n = 0;

  always #2 clk = ~clk;

  uart_cts_tx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .stop_code(stop_code),
    .mode_1x(mode_1x), .cts_en(cts_en), .cts_n(cts_n),
    .txd(txd), .tx_empty(tx_empty)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // one clock; sample line level once per tick period
  task automatic step();
    @(negedge clk);
    tick = ~tick;
    if (tick && n_smp < 2048) begin
      smp_txd[n_smp] = txd;
      smp_emp[n_smp] = tx_empty;
      n_smp++;
    end
  endtask

  task automatic push(input logic [7:0] d);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) step();
    step();
    in_valid = 1'b0;
  endtask

  task automatic add_bits(input bit v, input int n);
    for (int i = 0; i < n; i++) begin
      exp_txd[exp_n] = v;
      exp_n++;
    end
  endtask

  task automatic add_frame(input logic [7:0] d, input int len, input bit pe,
                           input bit po, input int sc, input bit x1);
    int bl;
    int sl;
    bit p;
    bl = x1 ? 1 : 16;
    p  = po;
    add_bits(1'b0, bl);
    for (int i = 0; i < len; i++) begin
      add_bits(d[i], bl);
      p ^= d[i];
    end
    if (pe) add_bits(p, bl);
    if (x1) sl = (sc >= 2) ? 2 : 1;
    else begin
      case (sc)
        0: sl = (len == 5) ? 16 : 9;
        1: sl = 16;
        2: sl = 24;
        default: sl = 32;
      endcase
    end
    add_bits(1'b1, sl);
  endtask

  task automatic compare(input string req, input int fend, input bit chk_emp);
    int f;
    int mism;
    int bad;
    f = -1;
    for (int i = 0; i < n_smp; i++)
      if (f < 0 && smp_txd[i] == 1'b0) f = i;
    if (f < 0) begin
      check(1'b0, req, "no start bit seen", 1, 0);
      return;
    end
    mism = 0;
    bad  = -1;
    for (int k = 0; k < exp_n; k++) begin
      if (f + k >= n_smp || smp_txd[f + k] != exp_txd[k]) begin
        mism++;
        if (bad < 0) bad = k;
      end
    end
    check(mism == 0, req, $sformatf("frame slot mismatches (first at slot %0d)", bad), mism, 0);
    if (chk_emp && f + fend < n_smp) begin
      check(smp_emp[f + fend - 1] == 1'b0 && smp_emp[f + fend] == 1'b1, "R10",
            "tx_empty at last stop slot/after it", {smp_emp[f + fend - 1], smp_emp[f + fend]}, 1);
    end
  endtask

  initial begin
    logic [7:0] a, b;
    int fend;
    string tag;
    repeat (4) step();
    rst_n = 1'b1;
    step();
    check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);

    // sweep every configuration with two back-to-back characters
    for (int cl = 0; cl < 4; cl++)
      for (int pm = 0; pm < 3; pm++)
        for (int sc = 0; sc < 4; sc++)
          for (int x = 0; x < 2; x++) begin
            char_len  = 2'(cl);
            par_en    = (pm != 0);
            par_odd   = (pm == 2);
            stop_code = 2'(sc);
            mode_1x   = x[0];
            cts_en    = 1'b0;
            cts_n     = 1'b1;
            a = 8'(cl * 61 + pm * 29 + sc * 7 + x * 3 + 5);
            b = ~a ^ 8'h5a;
            n_smp = 0;
            exp_n = 0;
            add_frame(a, cl + 5, pm != 0, pm == 2, sc, x[0]);
            add_frame(b, cl + 5, pm != 0, pm == 2, sc, x[0]);
            fend = exp_n;
            add_bits(1'b1, 16);
            push(a);
            push(b);
            check(in_ready == 1'b0, "R2", "in_ready with char shifting and one held", in_ready, 0);
            while (!tx_empty) step();
            repeat (40) step();
            tag = x ? "R6" : (pm != 0 ? "R4" : "R5");
            compare($sformatf("R3 R7 %s cfg len%0d par%0d stop%0d x%0d", tag, cl + 5, pm, sc, x),
                    fend, 1'b1);
          end

    char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0; stop_code = 2'd1; mode_1x = 1'b0;

    // CTS held off: line stays at mark, character stays held
    cts_en = 1'b1;
    cts_n  = 1'b1;
    n_smp  = 0;
    push(8'hA5);
    repeat (200) step();
    begin
      int zeros;
      zeros = 0;
      for (int i = 0; i < n_smp; i++) if (!smp_txd[i]) zeros++;
      check(zeros == 0, "R8", "low samples while cts_n high", zeros, 0);
      check(zeros == 0, "R11", "line idles high while blocked", zeros, 0);
    end
    check(in_ready == 1'b0, "R8", "character still held", in_ready, 0);
    check(tx_empty == 1'b0, "R10", "tx_empty while character pending", tx_empty, 0);

    // release, then toggle cts_n mid-character
    n_smp = 0;
    exp_n = 0;
    add_frame(8'hA5, 8, 1'b0, 1'b0, 1, 1'b0);
    fend = exp_n;
    add_bits(1'b1, 16);
    cts_n = 1'b0;
    repeat (80) step();
    cts_n = 1'b1;
    while (!tx_empty) step();
    repeat (40) step();
    compare("R9 cts_n raised mid-character", fend, 1'b1);

    // gating disabled: cts_n ignored
    cts_en = 1'b0;
    cts_n  = 1'b1;
    n_smp  = 0;
    exp_n  = 0;
    add_frame(8'h3C, 8, 1'b0, 1'b0, 1, 1'b0);
    fend = exp_n;
    add_bits(1'b1, 16);
    push(8'h3C);
    while (!tx_empty) step();
    repeat (40) step();
    compare("R8 cts_n ignored when gating off", fend, 1'b1);

    // boundary block: second character waits after first stop
    cts_en = 1'b1;
    cts_n  = 1'b0;
    n_smp  = 0;
    exp_n  = 0;
    add_frame(8'h81, 8, 1'b0, 1'b0, 1, 1'b0);
    fend = exp_n;
    add_bits(1'b1, 64);
    push(8'h81);
    push(8'h7E);
    cts_n = 1'b1;
    repeat (600) step();
    compare("R8 second character held at boundary", fend, 1'b0);
    check(in_ready == 1'b0, "R8", "second character still held", in_ready, 0);
    check(tx_empty == 1'b0, "R10", "tx_empty with held character", tx_empty, 0);
    n_smp = 0;
    exp_n = 0;
    add_frame(8'h7E, 8, 1'b0, 1'b0, 1, 1'b0);
    fend = exp_n;
    add_bits(1'b1, 16);
    cts_n = 1'b0;
    while (!tx_empty) step();
    repeat (40) step();
    compare("R8 held character sent after release", fend, 1'b1);
    check(txd == 1'b1, "R11", "txd idle with nothing to send", txd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule